// File: doc/BRIEF.md
# Timer Trigger and Start Controller

This block decides when a timer's counter begins a run and when an ongoing run is restarted. It takes eight hardware trigger lines and brings each one into the kernel clock domain through two flip-flops. A select field then picks one of the eight lines. The chosen line passes through a digital filter whose length can be set, and an edge detector turns the filtered level into trigger events according to a trigger-mode field. When the mode is software-only, a software start request is the only thing that can start a run.

A two-state machine records whether the timer is running. Its states are `ST_IDLE` and `ST_RUN`, and it has four named transitions:
- `IDLE->RUN` on a start event.
- `RUN->RUN (restart)` on an event that arrives while the timeout option is set.
- `RUN->RUN (hold)` on an event that arrives while the timeout option is clear. The event is ignored.
- `RUN->IDLE` on a stop request. From either state, stop forces `ST_IDLE`.

On each start the block emits a one-cycle start pulse together with a one-cycle counter-reset pulse. A restart emits only the counter-reset pulse. A downstream main counter and a repetition counter both clear on that pulse.

Top module: `trig_start_ctrl`

## Requirements
- R1: After reset, `start_pulse`, `cnt_rst_pulse` and `running` are all 0 and the state is `ST_IDLE`.
- R2: `trig_sel` (0 to 7) picks the trigger line `trig_in[trig_sel]`. Activity on any line that is not selected causes no pulse.
- R3: `trig_mode` selects what counts as an event. The encodings are: 0 = software start only, 1 = rising edge, 2 = falling edge, 3 = either edge. An edge of the opposite polarity in modes 1 and 2 causes no pulse.
- R4: `filt_code` values 0, 1, 2 and 3 set the filter length N to 1, 2, 4 and 8. The filter accepts a new level only after N consecutive synchronized samples at that level. A level change that lasts fewer than N cycles causes no event.
- R5: Consider a hardware edge on the selected line, driven before clock edge k. Its `start_pulse` and `cnt_rst_pulse` are high for exactly one cycle, after clock edge k+2+N. The delay is made up of two synchronizer stages, N filter samples and one registered output.
- R6: In mode 0, hardware triggers are ignored. A one-cycle `sw_start` that is sampled at a clock edge while idle produces the start and reset pulses after that same edge.
- R7: `running` rises with `start_pulse` and stays high until a stop.
- R8: With `timeout_en` = 0, an event that arrives while running produces no pulse.
- R9: With `timeout_en` = 1, an event that arrives while running produces a one-cycle `cnt_rst_pulse` with `start_pulse` low. It has the same latency as a start.
- R10: `stop` sampled high clears `running` at that edge and takes priority over a simultaneous event. The next valid event after a stop starts a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 8 | Asynchronous hardware trigger lines |
| trig_sel | input | 3 | Index of the trigger line in use |
| trig_mode | input | 2 | 0 software, 1 rising, 2 falling, 3 both edges |
| filt_code | input | 2 | Filter length code, N = 2^code |
| timeout_en | input | 1 | 1: mid-run events restart the counters |
| sw_start | input | 1 | Software start request (mode 0) |
| stop | input | 1 | Ends the run, returns to idle |
| start_pulse | output | 1 | One-cycle start of a new run |
| cnt_rst_pulse | output | 1 | One-cycle reset for the counter and the repetition counter |
| running | output | 1 | Timer is in a run |

## Verification
A wrong filter count or synchronizer depth moves the start pulse off cycle 3+N after the drive. This appears on the very first trigger of each configuration in the sweep. A state machine stuck in the wrong state shows up within one trigger: a missing or extra restart pulse during a run, or `running` failing to clear after a stop. A wrong select decode or polarity decode produces a pulse from a distractor line or from an edge of the wrong polarity within a few cycles.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [1:0] {
        TM_SOFT    = 2'd0,
        TM_RISE    = 2'd1,
        TM_FALL    = 2'd2,
        TM_BOTH    = 2'd3
    } trig_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end
        assign sync_out[g] = stab_q;
    end
endmodule

// File: rtl/tsc_filter.sv
module tsc_filter #(
    parameter int CODE_W = 2,
    localparam int MAX_N = 1 << ((1 << CODE_W) - 1),
    localparam int CNT_W = $clog2(MAX_N) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              sample,
    output logic              level
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_inc;

    assign need    = CNT_W'(1) << code;
    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            level <= 1'b0;
        end else if (sample != level) begin
            if (cnt_inc >= need) begin
                level <= sample;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_inc;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // R4
    filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(sample) == level));
endmodule

// File: rtl/tsc_edge.sv
module tsc_edge
    import tsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  trig_mode_t mode,
    output logic       hw_event
);
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

    always_comb begin
        unique case (mode)
            TM_SOFT: hw_event = 1'b0;
            TM_RISE: hw_event = rise;
            TM_FALL: hw_event = fall;
            TM_BOTH: hw_event = rise | fall;
        endcase
    end
endmodule

// File: rtl/trig_start_ctrl.sv
module trig_start_ctrl
    import tsc_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int FILT_W = 2,
    localparam int SEL_W = $clog2(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [1:0]        trig_mode,
    input  logic [FILT_W-1:0] filt_code,
    input  logic              timeout_en,
    input  logic              sw_start,
    input  logic              stop,
    output logic              start_pulse,
    output logic              cnt_rst_pulse,
    output logic              running
);
    logic [N_TRIG-1:0] trig_sync;
    logic              sel_raw;
    logic              filt_lvl;
    logic              hw_event;
    logic              event_any;
    trig_mode_t        mode;
    run_state_t        state_q, state_d;
    logic              start_d, rst_d;

    assign mode = trig_mode_t'(trig_mode);

    tsc_sync #(.WIDTH(N_TRIG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .sync_out(trig_sync)
    );

    assign sel_raw = trig_sync[trig_sel];

    tsc_filter #(.CODE_W(FILT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .code(filt_code),
        .sample(sel_raw), .level(filt_lvl)
    );

    tsc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level(filt_lvl),
        .mode(mode), .hw_event(hw_event)
    );

    assign event_any = (mode == TM_SOFT) ? sw_start : hw_event;

    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        rst_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!stop && event_any) begin
                    state_d = ST_RUN;
                    start_d = 1'b1;
                    rst_d   = 1'b1;
                end
            end
            ST_RUN: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end else if (event_any && timeout_en) begin
                    rst_d = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse   <= 1'b0;
            cnt_rst_pulse <= 1'b0;
        end else begin
            start_pulse   <= start_d;
            cnt_rst_pulse <= rst_d;
        end
    end

    assign running = (state_q == ST_RUN);

    // R5
    start_has_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> cnt_rst_pulse);
    // R7
    start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (running && !$past(running)));
    // R9
    restart_needs_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rst_pulse && !start_pulse) |-> ($past(timeout_en) && $past(running)));
    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(stop));
    // R10
    stop_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !start_pulse);
endmodule

// File: tb/trig_start_ctrl_tb.sv
module trig_start_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] trig_in = '0;
    logic [2:0] trig_sel = '0;
    logic [1:0] trig_mode = '0;
    logic [1:0] filt_code = '0;
    logic       timeout_en = 1'b0;
    logic       sw_start = 1'b0;
    logic       stop = 1'b0;
    logic       start_pulse, cnt_rst_pulse, running;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    trig_start_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel),
        .trig_mode(trig_mode), .filt_code(filt_code), .timeout_en(timeout_en),
        .sw_start(sw_start), .stop(stop), .start_pulse(start_pulse),
        .cnt_rst_pulse(cnt_rst_pulse), .running(running)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (sel=%0d mode=%0d filt=%0d)",
                     req, act, exp_v, trig_sel, trig_mode, filt_code);
        end
    endtask

    // Watch n cycles from the current negedge; report pulse counts and first latencies.
    task automatic watch(input int n, output int ns, output int nr,
                         output int ls, output int lr);
        ns = 0; nr = 0; ls = -1; lr = -1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (start_pulse) begin ns++; if (ls < 0) ls = i; end
            if (cnt_rst_pulse) begin nr++; if (lr < 0) lr = i; end
        end
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    initial begin
        int ns, nr, ls, lr, n_f, lat;
        logic base;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 start", start_pulse, 0);
        chk("R1 rst", cnt_rst_pulse, 0);
        chk("R1 running", running, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int m = 1; m <= 3; m++) begin
            for (int f = 0; f <= 3; f++) begin
                for (int s = 0; s <= 7; s++) begin
                    n_f = 1 << f;
                    lat = 3 + n_f;
                    trig_mode = m[1:0]; filt_code = f[1:0]; trig_sel = s[2:0];
                    timeout_en = 1'b0;
                    base = (m == 2);
                    trig_in = {8{base}};
                    watch(14, ns, nr, ls, lr);
                    do_stop();
                    chk("R10 idle after stop", running, 0);
                    // R2: distractor line toggles, selected stays
                    trig_in[(s + 1) % 8] = ~base;
                    watch(14, ns, nr, ls, lr);
                    chk("R2 unselected line", ns + nr, 0);
                    trig_in[(s + 1) % 8] = base;
                    // R4: glitch shorter than N
                    if (f > 0) begin
                        trig_in[s] = ~base;
                        repeat (n_f - 1) @(negedge clk);
                        trig_in[s] = base;
                        watch(14, ns, nr, ls, lr);
                        chk("R4 short glitch", ns, 0);
                    end
                    // R3: opposite polarity in modes 1 and 2 (via a preset level)
                    if (m != 3) begin
                        trig_in[s] = ~base;
                        watch(14, ns, nr, ls, lr);
                        do_stop();
                        trig_in[s] = base;
                        watch(14, ns, nr, ls, lr);
                        chk("R3 wrong polarity", ns, 0);
                    end
                    // R5: real start
                    trig_in[s] = ~base;
                    watch(14, ns, nr, ls, lr);
                    chk("R5 start latency", ls, lat);
                    chk("R5 start count", ns, 1);
                    chk("R5 reset latency", lr, lat);
                    chk("R7 running", running, 1);
                    // R8: event mid-run ignored
                    if (m == 3) begin
                        trig_in[s] = base;
                        watch(14, ns, nr, ls, lr);
                        chk("R8 ignored", ns + nr, 0);
                        trig_in[s] = ~base;
                        timeout_en = 1'b1;
                        watch(14, ns, nr, ls, lr);
                        chk("R9 restart reset", nr, 1);
                        chk("R9 restart latency", lr, lat);
                        chk("R9 no start", ns, 0);
                    end else begin
                        trig_in[s] = base;
                        watch(14, ns, nr, ls, lr);
                        chk("R7 still running", running, 1);
                    end
                    chk("R7 hold", running, 1);
                    do_stop();
                    chk("R10 stop", running, 0);
                end
            end
        end

        // R6: software mode
        trig_mode = 2'd0; filt_code = 2'd0; trig_sel = 3'd0; timeout_en = 1'b0;
        trig_in = 8'hFF;
        watch(10, ns, nr, ls, lr);
        trig_in = 8'h00;
        watch(10, ns, nr, ls, lr);
        chk("R6 hw ignored", ns + nr, 0);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        chk("R6 sw start", start_pulse, 1);
        chk("R6 sw reset", cnt_rst_pulse, 1);
        @(negedge clk);
        chk("R6 one cycle", start_pulse, 0);
        // R9 software restart with timeout
        timeout_en = 1'b1;
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        chk("R9 sw restart", cnt_rst_pulse, 1);
        chk("R9 sw no start", start_pulse, 0);
        // R10: stop wins over simultaneous start
        do_stop();
        stop = 1'b1; sw_start = 1'b1;
        @(negedge clk);
        stop = 1'b0; sw_start = 1'b0;
        chk("R10 stop priority", start_pulse, 0);
        chk("R10 stays idle", running, 0);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        chk("R10 fresh run", start_pulse, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule